// File: doc/BRIEF.md
# Layer-Selected Peripheral Register Window

This block gives a processor ten byte-wide device registers, addressed 0 to 9 through a plain synchronous write port with a combinational read port. Register 9 is the selector: the byte it holds names a peripheral layer. That layer decides what registers 0 to 8 mean. Only two layers do anything inside the block. The console layer turns each write to register 0 into one ASCII character, which appears on a character output as a one-cycle valid pulse with its data. The segment layer treats registers 0 to 8 as nine bytes of a 72-bit mask, and each bit of that mask drives one LCD segment.

Four further layer codes stand for timer, parallel-port, DMA and keypad/display controllers. Those controllers live outside the block. Here a window write under one of those codes only produces a one-cycle select strobe for that controller. The segment mask keeps its value when the selector moves to another layer, so the display stays lit while software prints to the console or talks to another device.

Top module: `layer_reg_window`

## Requirements
- R1: After reset the selector, every segment byte and the console character are zero, all 72 mask bits are off, con_valid and every layer_strobe bit are low, and every register reads as zero.
- R2: A write to register 9 stores the byte whatever its value. Register 9 reads back that byte under every layer.
- R3: While the selector holds 0xC0, a write to register 0 raises con_valid for the one cycle after the write edge, with con_char equal to the written byte. Writes in consecutive cycles give consecutive pulses, each carrying its own byte.
- R4: Under 0xC0, register 0 reads back the last character sent. Registers 1 to 8 read zero, and writes to them change no output.
- R5: While the selector holds 0xCB, a write to register k (0 to 8) replaces mask bits 8k+7 down to 8k. Register 0 bit 0 is segment 0 and register 8 bit 7 is segment 71.
- R6: Under 0xCB, registers 0 to 8 read back the mask byte they hold.
- R7: The mask changes only through writes to registers 0 to 8 under 0xCB. It holds its value across selector changes and across window writes under any other layer.
- R8: Under codes 0x53, 0x55, 0x57 and 0x79, a write to registers 0 to 8 pulses layer_strobe bit 0, 1, 2 or 3 respectively for one cycle and has no other effect. Registers 0 to 8 read zero. A write to register 9 never strobes.
- R9: Under any other selector value, window writes are ignored and raise no pulse. Registers 0 to 8 read zero. Indices 10 to 15 ignore writes and read zero under every layer.
- R10: At most one of con_valid and the layer_strobe bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for the register named by addr |
| addr | input | 4 | Register index: 0 to 8 window, 9 selector |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read of the register named by addr |
| con_valid | output | 1 | One-cycle pulse per console character |
| con_char | output | 8 | Console character, held until the next one |
| seg_mask | output | 72 | Segment mask, bit n drives segment n |
| layer_strobe | output | 4 | Select pulses for timer, parallel port, DMA and keypad layers |

## Verification
The assertions assume that wr_en, addr and wdata are settled and known at every rising edge after reset. They also assume that a pulse is caused only by a write in the previous cycle, so the selector value that counts is the one held before that edge. The bench drives every input on the falling edge and never changes addr and wdata around a rising edge. It drops wr_en between scenarios, so each pulse can be traced to exactly one write. Reads are sampled one time unit after the address is set on a falling edge. Pulse outputs are sampled on the falling edge that follows the write edge, and again one cycle later to confirm they dropped.

// File: rtl/lrw_pkg.sv
// Package: layer codes and the map classes shared by the register window.
// Assumes layer codes are one byte wide.
package lrw_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_CONSOLE = 8'hC0;
    localparam logic [CODE_W-1:0] CODE_SEGMENT = 8'hCB;

    // Strobe-only layers. Slice i selects layer_strobe bit i.
    localparam int NUM_STROBE = 4;
    localparam logic [NUM_STROBE*CODE_W-1:0] STROBE_CODES =
        {8'h79, 8'h57, 8'h55, 8'h53};

    typedef enum logic [1:0] {
        MAP_NONE    = 2'd0,
        MAP_CONSOLE = 2'd1,
        MAP_SEGMENT = 2'd2,
        MAP_STROBE  = 2'd3
    } map_e;

    // Sort a selector byte into the class of window it opens.
    function automatic map_e classify(input logic [CODE_W-1:0] code);
        map_e m;
        m = MAP_NONE;
        if (code == CODE_CONSOLE) begin
            m = MAP_CONSOLE;
        end else if (code == CODE_SEGMENT) begin
            m = MAP_SEGMENT;
        end else begin
            for (int i = 0; i < NUM_STROBE; i++) begin
                if (code == STROBE_CODES[i*CODE_W +: CODE_W]) begin
                    m = MAP_STROBE;
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/lrw_layer_sel.sv
// Selector register and layer decode.
// Holds the byte written to index SEL_IDX. Classifies it and flags which
// strobe-only layer it names, if any. Assumes DATA_W equals the code width.
module lrw_layer_sel
    import lrw_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int SEL_IDX = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     layer_code,
    output map_e                  layer_map,
    output logic [NUM_STROBE-1:0] strobe_hit
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_IDX);

    // Capture the selector on a write to its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layer_code <= '0;
        end else if (wr_en && addr == SEL_ADDR) begin
            layer_code <= wdata;
        end
    end

    // Classify the current selector value.
    always_comb begin
        layer_map = classify(layer_code);
    end

    // One match line per strobe-only layer.
    for (genvar g = 0; g < NUM_STROBE; g++) begin : g_hit
        assign strobe_hit[g] =
            (layer_code == STROBE_CODES[g*CODE_W +: CODE_W]);
    end

endmodule

// File: rtl/lrw_console_port.sv
// Console character output.
// A qualified write becomes a one-cycle valid pulse, with the byte held on
// con_char until the next character. Assumes wr_hit is already qualified by
// the console layer and index 0.
module lrw_console_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              con_valid,
    output logic [DATA_W-1:0] con_char
);

    // Register the pulse and the character together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            con_valid <= 1'b0;
            con_char  <= '0;
        end else begin
            con_valid <= wr_hit;
            if (wr_hit) begin
                con_char <= wdata;
            end
        end
    end

endmodule

// File: rtl/lrw_segment_bank.sv
// Segment mask storage.
// NUM_WIN byte registers are concatenated so that byte k owns mask bits
// 8k+7..8k. Also returns the byte named by addr for readback. Assumes wr_sel
// is already qualified by the segment layer.
module lrw_segment_bank #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int NUM_WIN = 9,
    localparam int MASK_W = NUM_WIN * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic [MASK_W-1:0] mask
);

    logic [DATA_W-1:0] bank [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_byte
        // Update one mask byte when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (wr_sel && addr == ADDR_W'(g)) begin
                bank[g] <= wdata;
            end
        end
        assign mask[g*DATA_W +: DATA_W] = bank[g];
    end

    // Pick the addressed byte; out-of-range indices read zero.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_byte = bank[i];
            end
        end
    end

endmodule

// File: rtl/lrw_strobe_gen.sv
// Select strobes for the strobe-only layers.
// A window write under a matching layer gives a one-cycle pulse on that
// layer's bit. Assumes strobe_hit has at most one bit set.
module lrw_strobe_gen #(
    parameter int NUM_STROBE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_wr,
    input  logic [NUM_STROBE-1:0] strobe_hit,
    output logic [NUM_STROBE-1:0] layer_strobe
);

    for (genvar g = 0; g < NUM_STROBE; g++) begin : g_stb
        // Pulse this layer's strobe for one cycle per window write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                layer_strobe[g] <= 1'b0;
            end else begin
                layer_strobe[g] <= win_wr && strobe_hit[g];
            end
        end
    end

endmodule

// File: rtl/layer_reg_window.sv
// Top of the layer-selected peripheral register window.
// Index SEL_IDX holds the layer selector. Indices 0..NUM_WIN-1 form the
// window it remaps. Reads are combinational from addr. Assumes the write
// inputs are stable around each rising clock edge.
module layer_reg_window
    import lrw_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int NUM_WIN = 9,
    parameter int SEL_IDX = 9,
    localparam int MASK_W = NUM_WIN * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  con_valid,
    output logic [DATA_W-1:0]     con_char,
    output logic [MASK_W-1:0]     seg_mask,
    output logic [NUM_STROBE-1:0] layer_strobe
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_IDX);
    localparam logic [ADDR_W-1:0] WIN_LIM  = ADDR_W'(NUM_WIN);

    logic [DATA_W-1:0]     layer_code;
    map_e                  layer_map;
    logic [NUM_STROBE-1:0] strobe_hit;
    logic                  in_window;
    logic                  win_wr;
    logic [DATA_W-1:0]     seg_rd;

    // Decide whether addr falls inside the remapped window.
    always_comb begin
        in_window = (addr < WIN_LIM);
        win_wr    = wr_en && in_window;
    end

    lrw_layer_sel #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .SEL_IDX (SEL_IDX)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .layer_code (layer_code),
        .layer_map  (layer_map),
        .strobe_hit (strobe_hit)
    );

    lrw_console_port #(
        .DATA_W (DATA_W)
    ) u_con (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_en && addr == '0 && layer_map == MAP_CONSOLE),
        .wdata     (wdata),
        .con_valid (con_valid),
        .con_char  (con_char)
    );

    lrw_segment_bank #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_WIN (NUM_WIN)
    ) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (win_wr && layer_map == MAP_SEGMENT),
        .addr    (addr),
        .wdata   (wdata),
        .rd_byte (seg_rd),
        .mask    (seg_mask)
    );

    lrw_strobe_gen #(
        .NUM_STROBE (NUM_STROBE)
    ) u_stb (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_wr       (win_wr),
        .strobe_hit   (strobe_hit),
        .layer_strobe (layer_strobe)
    );

    // Read mux: the selector always, the window per layer, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr == SEL_ADDR) begin
            rdata = layer_code;
        end else if (in_window) begin
            unique case (layer_map)
                MAP_CONSOLE: rdata = (addr == '0) ? con_char : '0;
                MAP_SEGMENT: rdata = seg_rd;
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/lrw_checker.sv
// Checker for layer_reg_window, bound to every instance of it.
// Assumes the write inputs are known at each rising edge after reset.
module lrw_checker #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int NUM_WIN    = 9,
    parameter int SEL_IDX    = 9,
    parameter int NUM_STROBE = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [DATA_W-1:0]         wdata,
    input logic                      con_valid,
    input logic [DATA_W-1:0]         con_char,
    input logic [NUM_WIN*DATA_W-1:0] seg_mask,
    input logic [NUM_STROBE-1:0]     layer_strobe,
    input logic [DATA_W-1:0]         layer_code
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_IDX);
    localparam logic [ADDR_W-1:0] WIN_LIM  = ADDR_W'(NUM_WIN);

    // R2: the selector takes the byte written to its index.
    a_r2_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_ADDR) |=> (layer_code == $past(wdata)));

    // R3: a console pulse follows only a write to index 0 under 0xC0.
    a_r3_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid |-> $past(wr_en && addr == '0 && layer_code == 8'hC0));

    // R3: the pulse carries the written byte.
    a_r3_char_data: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid |-> (con_char == $past(wdata)));

    // R7: without a segment-layer window write the mask stays put.
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr < WIN_LIM && layer_code == 8'hCB) |=> $stable(seg_mask));

    // R8: a strobe follows only a window write.
    a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|layer_strobe) |-> $past(wr_en && addr < WIN_LIM));

    // R10: pulses never overlap.
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({layer_strobe, con_valid}));

endmodule

bind layer_reg_window lrw_checker #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_WIN    (NUM_WIN),
    .SEL_IDX    (SEL_IDX),
    .NUM_STROBE (lrw_pkg::NUM_STROBE)
) u_lrw_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .con_valid    (con_valid),
    .con_char     (con_char),
    .seg_mask     (seg_mask),
    .layer_strobe (layer_strobe),
    .layer_code   (layer_code)
);

// File: tb/tb_layer_reg_window.sv
module tb_layer_reg_window;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        con_valid;
    logic [7:0]  con_char;
    logic [71:0] seg_mask;
    logic [3:0]  layer_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [71:0] exp_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    layer_reg_window dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .con_valid    (con_valid),
        .con_char     (con_char),
        .seg_mask     (seg_mask),
        .layer_strobe (layer_strobe)
    );

    task automatic check(input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Single-cycle write; returns on the falling edge after the write edge.
    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1", "seg_mask", seg_mask, '0);
        check("R1", "con_valid", con_valid, 0);
        check("R1", "layer_strobe", layer_strobe, 0);
        for (int i = 0; i < 10; i++) begin
            do_read(4'(i), v);
            check("R1", "read", v, 0);
        end
    endtask

    task automatic t_selector();
        logic [7:0] v;
        do_write(9, 8'hA5);
        do_read(9, v);
        check("R2", "selector readback", v, 8'hA5);
        do_write(9, 8'hCB);
        do_read(9, v);
        check("R2", "selector readback under 0xCB", v, 8'hCB);
    endtask

    task automatic t_console();
        logic [7:0] v;
        do_write(9, 8'hC0);
        do_write(0, 8'h48);
        check("R3", "valid on write", con_valid, 1);
        check("R3", "char", con_char, 8'h48);
        @(negedge clk);
        check("R3", "valid drops", con_valid, 0);
        // back-to-back characters
        wr_en = 1'b1; addr = 0; wdata = 8'h69;
        @(negedge clk);
        wdata = 8'h21;
        check("R3", "first of pair valid", con_valid, 1);
        check("R3", "first of pair char", con_char, 8'h69);
        @(negedge clk);
        wr_en = 1'b0;
        check("R3", "second of pair valid", con_valid, 1);
        check("R3", "second of pair char", con_char, 8'h21);
        @(negedge clk);
        check("R3", "valid drops after pair", con_valid, 0);
        do_read(0, v);
        check("R4", "last char readback", v, 8'h21);
        do_write(3, 8'h77);
        check("R4", "no pulse on D3 write", con_valid, 0);
        check("R4", "char unchanged", con_char, 8'h21);
        check("R4", "mask untouched", seg_mask, exp_mask);
        do_read(3, v);
        check("R4", "D3 reads zero", v, 0);
    endtask

    task automatic t_segment();
        logic [7:0] v;
        do_write(9, 8'hCB);
        do_write(0, 8'h01);
        exp_mask[7:0] = 8'h01;
        check("R5", "segment 0 on", seg_mask, exp_mask);
        do_write(8, 8'h80);
        exp_mask[71:64] = 8'h80;
        check("R5", "segment 71 on", seg_mask, exp_mask);
        do_write(4, 8'h3C);
        exp_mask[39:32] = 8'h3C;
        check("R5", "byte 4 placed", seg_mask, exp_mask);
        check("R10", "no pulses on segment write", {layer_strobe, con_valid}, 0);
        do_read(4, v);
        check("R6", "byte 4 readback", v, 8'h3C);
        do_read(8, v);
        check("R6", "byte 8 readback", v, 8'h80);
        do_read(12, v);
        check("R9", "index 12 reads zero", v, 0);
        do_write(12, 8'hFF);
        check("R9", "index 12 write ignored", seg_mask, exp_mask);
        do_read(9, v);
        check("R9", "selector kept after index 12 write", v, 8'hCB);
    endtask

    task automatic t_strobes();
        logic [7:0] codes [4] = '{8'h53, 8'h55, 8'h57, 8'h79};
        logic [7:0] v;
        do_write(9, 8'hC0);
        do_write(2, 8'hFF);
        check("R7", "mask held under console", seg_mask, exp_mask);
        for (int i = 0; i < 4; i++) begin
            do_write(9, codes[i]);
            check("R8", "no strobe on selector write", layer_strobe, 0);
            do_write(4'(i), 8'hEE);
            check("R8", "strobe bit", layer_strobe, 72'(1 << i));
            check("R10", "no console pulse", con_valid, 0);
            @(negedge clk);
            check("R8", "strobe drops", layer_strobe, 0);
            check("R7", "mask held under strobe layer", seg_mask, exp_mask);
            do_read(4'(i), v);
            check("R8", "window reads zero", v, 0);
        end
        do_write(9, 8'hCB);
        do_read(2, v);
        check("R7", "byte 2 still zero", v, 0);
    endtask

    task automatic t_unknown();
        logic [7:0] v;
        do_write(9, 8'h12);
        do_write(0, 8'h5A);
        check("R9", "no strobe under unknown code", layer_strobe, 0);
        check("R9", "no console pulse under unknown code", con_valid, 0);
        check("R9", "mask held under unknown code", seg_mask, exp_mask);
        do_read(0, v);
        check("R9", "window reads zero", v, 0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_selector();
        t_console();
        t_segment();
        t_strobes();
        t_unknown();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule